// File: doc/BRIEF.md
# Framed Packet Receiver with CRC32 Check

This block sits behind a byte-wide receive stream, such as the output of a serial receiver, and pulls framed packets out of it. It hunts for a start-of-frame byte, reads a length byte, takes that many payload bytes into a local store, collects a four-byte CRC32 trailer and expects an end-of-frame byte. It then decides whether the frame is good. It answers on a byte transmit port with an acknowledge or a negative-acknowledge code. Only after that code has been taken does it hand the payload of a good frame downstream on a valid/ready stream, with a marker on the final byte.

Because the payload is held until the verdict is known, downstream logic never sees bytes from a bad frame. A single-cycle verdict strobe with a good/bad flag tells downstream logic that a frame has ended and whether its payload will follow or has been discarded. The store depth is a parameter. A frame that announces more bytes than the store holds is still consumed to its end, but it is rejected.

Top module: `pkt_rx_crc_top`

## Requirements
- R1: While hunting for a frame, every byte other than 0x02 is dropped without any response, verdict or payload output. The byte 0x02 starts a frame.
- R2: The byte after 0x02 gives the payload length. Values 0x01 to 0xFF mean that many bytes, and 0x00 means 256 bytes.
- R3: The trailer is the CRC32 of the payload bytes only, sent least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from 0xFFFFFFFF and is inverted at the end. A frame is good only if the trailer matches.
- R4: A good frame is answered with the response byte 0x06. A bad frame is answered with 0x15. The response is offered on the transmit port in the cycle after the end byte is accepted.
- R5: If the byte after the trailer is not 0x03, the frame is bad and its payload is never delivered.
- R6: If the trailer does not match the computed CRC32, the frame is bad and its payload is never delivered.
- R7: A payload byte of 0x00 makes the frame bad, even when the CRC matches.
- R8: A length above MAX_LEN makes the frame bad. The announced number of bytes is still consumed, and the receiver then hunts for the next frame.
- R9: The payload of a good frame is delivered in arrival order, and only after the response byte has been accepted. The last-byte flag is high on exactly the final byte, and data and flag hold steady while the consumer stalls.
- R10: The input ready is low from acceptance of the end byte until the response and any payload have been fully delivered. The response byte holds steady until it is accepted.
- R11: The verdict strobe is high for exactly one cycle, the first cycle the response is offered. Its good flag is high exactly when the response is 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Receiver can take a byte |
| pay_valid | output | 1 | Payload byte present |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte of the frame |
| pay_ready | input | 1 | Consumer takes the payload byte |
| rsp_valid | output | 1 | Response byte present |
| rsp_data | output | 8 | Response code, 0x06 or 0x15 |
| rsp_ready | input | 1 | Transmitter takes the response byte |
| verdict_valid | output | 1 | One-cycle strobe at end of frame |
| verdict_good | output | 1 | Frame good (payload will follow) |

## Verification
The bench builds two copies of the block. One keeps the default MAX_LEN of 256, so the length code 0x00 can be sent as a full 256-byte frame. The other has MAX_LEN of 16, where a frame of 20 bytes overruns the store and a frame of exactly 16 fills it. This brings the over-length rejection and the resynchronisation after it within reach at small cost. On both copies the payload consumer stalls in a fixed pattern, and the response is held back for several cycles before it is taken.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

   localparam logic [7:0] SOF_CHAR = 8'h02;
   localparam logic [7:0] EOF_CHAR = 8'h03;
   localparam logic [7:0] ACK_CHAR = 8'h06;
   localparam logic [7:0] NAK_CHAR = 8'h15;

   localparam int LEN_W = 9;

   typedef enum logic [2:0] {
      ST_HUNT,
      ST_LEN,
      ST_BODY,
      ST_CHK,
      ST_TAIL,
      ST_REPLY,
      ST_FLUSH
   } rx_state_t;

   function automatic logic [LEN_W-1:0] len_decode(input logic [7:0] code);
      return (code == 8'h00) ? LEN_W'(256) : {1'b0, code};
   endfunction

endpackage

// File: rtl/pkt_rx_crc32.sv
module pkt_rx_crc32 #(
   parameter logic [31:0] POLY = 32'hEDB88320,
   parameter logic [31:0] SEED = 32'hFFFFFFFF,
   parameter int          BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            en,
   input  logic [BITS-1:0] data,
   output logic [31:0]     crc_final
);

   logic [31:0] crc_q;
   logic [31:0] stage [0:BITS];

   assign stage[0] = crc_q ^ {{(32-BITS){1'b0}}, data};

   for (genvar i = 0; i < BITS; i++) begin : g_bit
      assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY) : (stage[i] >> 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= SEED;
      else if (clr)   crc_q <= SEED;
      else if (en)    crc_q <= stage[BITS];
   end

   assign crc_final = ~crc_q;

   a_r3_clear_seed: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (crc_final == ~SEED));

endmodule

// File: rtl/pkt_rx_store.sv
module pkt_rx_store #(
   parameter int DEPTH = 256,
   parameter int WIDTH = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pkt_rx_seq.sv
module pkt_rx_seq
   import pkt_rx_pkg::*;
#(
   parameter int MAX_LEN = 256,
   localparam int AW     = $clog2(MAX_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [7:0]    in_data,
   output logic          in_ready,
   output logic          crc_clr,
   output logic          crc_en,
   input  logic [31:0]   crc_final,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   input  logic [7:0]    rd_data,
   output logic          pay_valid,
   output logic [7:0]    pay_data,
   output logic          pay_last,
   input  logic          pay_ready,
   output logic          rsp_valid,
   output logic [7:0]    rsp_data,
   input  logic          rsp_ready,
   output logic          verdict_valid,
   output logic          verdict_good
);

   rx_state_t        state_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] idx_q;
   logic [1:0]       chk_q;
   logic [31:0]      rxcrc_q;
   logic             flaw_q;
   logic             good_q;
   logic             verdict_q;

   logic             take;
   logic [LEN_W-1:0] len_dec;
   logic             len_over;
   logic             at_end;

   always_comb begin
      in_ready = (state_q == ST_HUNT) || (state_q == ST_LEN) || (state_q == ST_BODY) ||
                 (state_q == ST_CHK)  || (state_q == ST_TAIL);
      take     = in_valid && in_ready;
      len_dec  = len_decode(in_data);
      len_over = int'(len_dec) > MAX_LEN;
      at_end   = (idx_q == len_q - LEN_W'(1));
   end

   assign crc_clr  = take && (state_q == ST_HUNT) && (in_data == SOF_CHAR);
   assign crc_en   = take && (state_q == ST_BODY);
   assign wr_en    = crc_en && (int'(idx_q) < MAX_LEN);
   assign wr_addr  = idx_q[AW-1:0];
   assign rd_addr  = idx_q[AW-1:0];

   assign pay_valid     = (state_q == ST_FLUSH);
   assign pay_data      = rd_data;
   assign pay_last      = pay_valid && at_end;
   assign rsp_valid     = (state_q == ST_REPLY);
   assign rsp_data      = good_q ? ACK_CHAR : NAK_CHAR;
   assign verdict_valid = verdict_q;
   assign verdict_good  = good_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_HUNT;
         len_q     <= '0;
         idx_q     <= '0;
         chk_q     <= '0;
         rxcrc_q   <= '0;
         flaw_q    <= 1'b0;
         good_q    <= 1'b0;
         verdict_q <= 1'b0;
      end else begin
         verdict_q <= 1'b0;
         unique case (state_q)
            ST_HUNT: begin
               if (take && (in_data == SOF_CHAR)) state_q <= ST_LEN;
            end
            ST_LEN: begin
               if (take) begin
                  len_q   <= len_dec;
                  idx_q   <= '0;
                  flaw_q  <= len_over;
                  state_q <= ST_BODY;
               end
            end
            ST_BODY: begin
               if (take) begin
                  if (in_data == 8'h00) flaw_q <= 1'b1;
                  if (at_end) begin
                     chk_q   <= '0;
                     state_q <= ST_CHK;
                  end else begin
                     idx_q <= idx_q + LEN_W'(1);
                  end
               end
            end
            ST_CHK: begin
               if (take) begin
                  rxcrc_q[{chk_q, 3'b000} +: 8] <= in_data;
                  chk_q <= chk_q + 2'd1;
                  if (chk_q == 2'd3) state_q <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (take) begin
                  good_q    <= (in_data == EOF_CHAR) && !flaw_q && (crc_final == rxcrc_q);
                  verdict_q <= 1'b1;
                  state_q   <= ST_REPLY;
               end
            end
            ST_REPLY: begin
               if (rsp_ready) begin
                  idx_q   <= '0;
                  state_q <= good_q ? ST_FLUSH : ST_HUNT;
               end
            end
            ST_FLUSH: begin
               if (pay_ready) begin
                  if (at_end) state_q <= ST_HUNT;
                  else        idx_q   <= idx_q + LEN_W'(1);
               end
            end
            default: state_q <= ST_HUNT;
         endcase
      end
   end

   a_r4_reply_code: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_data == ACK_CHAR || rsp_data == NAK_CHAR));

   a_r9_flush_only_good: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid |-> verdict_good);

   a_r9_pay_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_valid && !pay_ready) |=> (pay_valid && $stable(pay_data) && $stable(pay_last)));

   a_r10_reply_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

   a_r10_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || pay_valid) |-> !in_ready);

   a_r11_verdict_with_reply: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_valid |-> rsp_valid);

   a_r11_verdict_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_valid |=> !verdict_valid);

   a_r8_store_bound: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) < MAX_LEN));

endmodule

// File: rtl/pkt_rx_crc_top.sv
module pkt_rx_crc_top #(
   parameter int          MAX_LEN  = 256,
   parameter logic [31:0] CRC_POLY = 32'hEDB88320,
   parameter logic [31:0] CRC_SEED = 32'hFFFFFFFF,
   localparam int         AW       = $clog2(MAX_LEN)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   output logic       in_ready,
   output logic       pay_valid,
   output logic [7:0] pay_data,
   output logic       pay_last,
   input  logic       pay_ready,
   output logic       rsp_valid,
   output logic [7:0] rsp_data,
   input  logic       rsp_ready,
   output logic       verdict_valid,
   output logic       verdict_good
);

   if (MAX_LEN < 2 || MAX_LEN > 256) begin : g_len_check
      $error("pkt_rx_crc_top: MAX_LEN must lie in 2..256");
   end

   logic          crc_clr;
   logic          crc_en;
   logic [31:0]   crc_final;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data;

   pkt_rx_crc32 #(
      .POLY (CRC_POLY),
      .SEED (CRC_SEED),
      .BITS (8)
   ) crc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (crc_clr),
      .en        (crc_en),
      .data      (in_data),
      .crc_final (crc_final)
   );

   pkt_rx_store #(
      .DEPTH (MAX_LEN),
      .WIDTH (8)
   ) store_i (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (in_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   pkt_rx_seq #(
      .MAX_LEN (MAX_LEN)
   ) seq_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_data       (in_data),
      .in_ready      (in_ready),
      .crc_clr       (crc_clr),
      .crc_en        (crc_en),
      .crc_final     (crc_final),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .rd_addr       (rd_addr),
      .rd_data       (rd_data),
      .pay_valid     (pay_valid),
      .pay_data      (pay_data),
      .pay_last      (pay_last),
      .pay_ready     (pay_ready),
      .rsp_valid     (rsp_valid),
      .rsp_data      (rsp_data),
      .rsp_ready     (rsp_ready),
      .verdict_valid (verdict_valid),
      .verdict_good  (verdict_good)
   );

endmodule

// File: tb/pkt_rx_crc_top_tb_top.sv
module pkt_rx_crc_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SMALL_LEN  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   logic       in_valid  [2];
   logic [7:0] in_data   [2];
   logic       in_ready  [2];
   logic       pay_valid [2];
   logic [7:0] pay_data  [2];
   logic       pay_last  [2];
   logic       pay_ready [2];
   logic       rsp_valid [2];
   logic [7:0] rsp_data  [2];
   logic       rsp_ready [2];
   logic       vd_valid  [2];
   logic       vd_good   [2];

   int         vectors = 0;
   int         fails   = 0;
   logic [7:0] tx_pl [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   pkt_rx_crc_top dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid[0]), .in_data(in_data[0]), .in_ready(in_ready[0]),
      .pay_valid(pay_valid[0]), .pay_data(pay_data[0]), .pay_last(pay_last[0]),
      .pay_ready(pay_ready[0]), .rsp_valid(rsp_valid[0]), .rsp_data(rsp_data[0]),
      .rsp_ready(rsp_ready[0]), .verdict_valid(vd_valid[0]), .verdict_good(vd_good[0]));

   pkt_rx_crc_top #(.MAX_LEN(SMALL_LEN)) dut_small_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid[1]), .in_data(in_data[1]), .in_ready(in_ready[1]),
      .pay_valid(pay_valid[1]), .pay_data(pay_data[1]), .pay_last(pay_last[1]),
      .pay_ready(pay_ready[1]), .rsp_valid(rsp_valid[1]), .rsp_data(rsp_data[1]),
      .rsp_ready(rsp_ready[1]), .verdict_valid(vd_valid[1]), .verdict_good(vd_good[1]));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] crc_ref(input int len);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < len; i++) begin
         for (int b = 0; b < 8; b++) begin
            if (c[0] ^ tx_pl[i][b]) c = (c >> 1) ^ 32'hEDB88320;
            else                    c = c >> 1;
         end
      end
      return ~c;
   endfunction

   task automatic fill(input int len, input int seed);
      for (int i = 0; i < len; i++) tx_pl[i] = 8'(8'h21 + ((i * 7 + seed) % 90));
   endtask

   task automatic send_byte(input int s, input logic [7:0] b);
      int guard = 0;
      @(negedge clk);
      while (!in_ready[s] && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      in_valid[s] = 1'b1;
      in_data[s]  = b;
      @(negedge clk);
      in_valid[s] = 1'b0;
   endtask

   task automatic send_frame(input int s, input int len, input bit bad_crc,
                             input logic [7:0] tail);
      logic [31:0] c = crc_ref(len);
      if (bad_crc) c = c ^ 32'h0000_0100;
      send_byte(s, 8'h02);
      send_byte(s, 8'(len));
      for (int i = 0; i < len; i++) send_byte(s, tx_pl[i]);
      for (int k = 0; k < 4; k++) send_byte(s, c[8*k +: 8]);
      send_byte(s, tail);
   endtask

   task automatic expect_reply(input int s, input bit good, input int len, input string req);
      logic [7:0] code = good ? 8'h06 : 8'h15;
      int n = 0;
      int k = 0;
      int bad_bytes = 0;
      int last_at = -1;
      int last_cnt = 0;
      check(rsp_valid[s] == 1'b1, "R4", {req, " response offered"}, int'(rsp_valid[s]), 1);
      check(rsp_data[s] == code, req, "response code", int'(rsp_data[s]), int'(code));
      check(vd_valid[s] == 1'b1, "R11", "verdict strobe", int'(vd_valid[s]), 1);
      check(vd_good[s] == good, "R11", "verdict good flag", int'(vd_good[s]), int'(good));
      check(in_ready[s] == 1'b0, "R10", "intake stalled", int'(in_ready[s]), 0);
      @(negedge clk);
      @(negedge clk);
      check(rsp_valid[s] && rsp_data[s] == code, "R10", "response held", int'(rsp_data[s]), int'(code));
      check(vd_valid[s] == 1'b0, "R11", "verdict single cycle", int'(vd_valid[s]), 0);
      check(pay_valid[s] == 1'b0, "R9", "no payload before reply taken", int'(pay_valid[s]), 0);
      rsp_ready[s] = 1'b1;
      @(negedge clk);
      rsp_ready[s] = 1'b0;
      if (!good) begin
         check(pay_valid[s] == 1'b0, req, "bad payload discarded", int'(pay_valid[s]), 0);
         check(in_ready[s] == 1'b1, req, "back to hunting", int'(in_ready[s]), 1);
      end else begin
         while (n < len && k < 4 * len + 20) begin
            logic pr = (k % 3) != 2;
            pay_ready[s] = pr;
            if (pay_valid[s] && pr) begin
               if (pay_data[s] != tx_pl[n]) bad_bytes++;
               if (pay_last[s]) begin
                  last_at = n;
                  last_cnt++;
               end
               n++;
            end
            @(negedge clk);
            k++;
         end
         pay_ready[s] = 1'b0;
         check(n == len, "R9", "payload count", n, len);
         check(bad_bytes == 0, "R9", "payload bytes in order", bad_bytes, 0);
         check(last_cnt == 1 && last_at == len - 1, "R9", "last flag position", last_at, len - 1);
         check(in_ready[s] == 1'b1 && pay_valid[s] == 1'b0, "R10", "intake reopened",
               int'(in_ready[s]), 1);
      end
   endtask

   task automatic t_reset();
      for (int s = 0; s < 2; s++) begin
         check(in_ready[s] == 1'b1, "R1", "reset hunting", int'(in_ready[s]), 1);
         check(!pay_valid[s] && !rsp_valid[s] && !vd_valid[s], "R4", "reset outputs idle",
               int'(rsp_valid[s]), 0);
      end
   endtask

   task automatic t_junk_then_good();
      logic [7:0] junk [5] = '{8'h41, 8'h03, 8'h06, 8'h15, 8'h00};
      foreach (junk[j]) send_byte(0, junk[j]);
      @(negedge clk);
      check(!rsp_valid[0] && !vd_valid[0] && !pay_valid[0], "R1", "junk ignored",
            int'(rsp_valid[0]), 0);
      check(in_ready[0] == 1'b1, "R1", "still hunting", int'(in_ready[0]), 1);
      fill(5, 3);
      send_frame(0, 5, 1'b0, 8'h03);
      expect_reply(0, 1'b1, 5, "R3");
   endtask

   task automatic t_full_length();
      fill(256, 11);
      send_frame(0, 256, 1'b0, 8'h03);
      expect_reply(0, 1'b1, 256, "R2");
   endtask

   task automatic t_single_byte();
      fill(1, 40);
      send_frame(0, 1, 1'b0, 8'h03);
      expect_reply(0, 1'b1, 1, "R2");
   endtask

   task automatic t_bad_tail();
      fill(7, 5);
      send_frame(0, 7, 1'b0, 8'h04);
      expect_reply(0, 1'b0, 7, "R5");
   endtask

   task automatic t_bad_crc();
      fill(9, 2);
      send_frame(0, 9, 1'b1, 8'h03);
      expect_reply(0, 1'b0, 9, "R6");
   endtask

   task automatic t_zero_byte();
      fill(6, 8);
      tx_pl[2] = 8'h00;
      send_frame(0, 6, 1'b0, 8'h03);
      expect_reply(0, 1'b0, 6, "R7");
   endtask

   task automatic t_over_length();
      fill(20, 1);
      send_frame(1, 20, 1'b0, 8'h03);
      expect_reply(1, 1'b0, 20, "R8");
      fill(SMALL_LEN, 17);
      send_frame(1, SMALL_LEN, 1'b0, 8'h03);
      expect_reply(1, 1'b1, SMALL_LEN, "R8");
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      fails++;
      $display("FAIL watchdog expired (R10 progress)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      for (int s = 0; s < 2; s++) begin
         in_valid[s] = 1'b0; in_data[s] = 8'h00;
         pay_ready[s] = 1'b0; rsp_ready[s] = 1'b0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_junk_then_good();
      t_full_length();
      t_single_byte();
      t_bad_tail();
      t_bad_crc();
      t_zero_byte();
      t_over_length();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule